// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer. It works with an external dual-modulus prescaler. Each clock edge it receives is one output pulse of that prescaler. The block drives the prescaler's modulus-select line: high asks for base modulus plus one, low asks for the base modulus. A frame lasts as many prescaler pulses as the main count. The swallow count sets how many of those pulses, at the start of the frame, run at the larger modulus. With base modulus P, main count N and swallow count A (A below N), one frame therefore spans P·N + A cycles of the oscillator. A one-cycle comparison pulse marks the last prescaler pulse of each frame.

A separate reference counter in its own clock domain divides the reference clock and produces a one-cycle reference pulse. The phase comparator downstream uses the comparison pulse and the reference pulse as its two inputs.

The configuration values come from holding registers. The block samples them only at frame boundaries, so software can rewrite them at any time without shortening a frame. An enable input puts both counters into an idle state.

Top module: `swallowDivider`

## Requirements
- R1: With enable high, the comparison pulse `fpPulse` is high for exactly one prescaler cycle. The pulses are spaced max(N,5) prescaler cycles apart, where N is `mainCfg` read as an unsigned binary number.
- R2: In every frame, `modCtl` is high on the first A prescaler cycles, counted from the cycle after the comparison pulse, and low for the rest of the frame. A is `swallowCfg` read as unsigned binary, 0 to 127, and must be below the effective N. When A is 0, `modCtl` stays low for the whole frame.
- R3: Counting P+1 oscillator cycles for each frame cycle with `modCtl` high and P for each cycle with it low gives P·N + A per frame, for both P = 64 and P = 128.
- R4: A `mainCfg` value below 5 behaves exactly as 5.
- R5: With enable high, `frPulse` is high for exactly one reference cycle. The pulses are spaced max(R,5) reference cycles apart, where R is `refCfg` read as unsigned binary; values below 5 behave as 5.
- R6: A change to `mainCfg` or `swallowCfg` made after a frame has started does not affect that frame. It takes effect in the next frame.
- R7: While enable is low, all three outputs are low from the second edge onward of the domain that drives them. After enable rises, the first comparison pulse appears on the N-th prescaler cycle following the first edge that samples enable high.
- R8: While `rstN` is low, `modCtl`, `fpPulse` and `frPulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pscClk | input | 1 | Prescaler output clock; one edge per prescaler pulse |
| refClk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| enable | input | 1 | Run when high, idle when low |
| swallowCfg | input | 7 | Swallow count A |
| mainCfg | input | 11 | Main count N (values below 5 are clamped) |
| refCfg | input | 14 | Reference count R (values below 5 are clamped) |
| modCtl | output | 1 | Modulus select to the prescaler: 1 selects P+1, 0 selects P |
| fpPulse | output | 1 | One-cycle comparison pulse at the end of each frame |
| frPulse | output | 1 | One-cycle reference pulse every R reference cycles |

## Verification
A corrupted main remainder changes the spacing of `fpPulse` in the frame where it happens. A corrupted swallow remainder changes the number of `modCtl`-high cycles in that same frame. Both faults therefore show up within one frame, at most 2047 prescaler cycles. A reload taken at the wrong time shows up in the frame after a mid-frame configuration change as the wrong frame length. A fault in the reference counter shows up within one reference period as a changed `frPulse` spacing. The bench measures these spacings and counts directly at the ports.

// File: rtl/swallowDivider_pkg.sv
package swallowDivider_pkg;

  // Strobes from the frame control to the counter datapath.
  typedef struct packed {
    logic clear;  // enable is low: park the counters
    logic load;   // frame boundary: reload from configuration
    logic step;   // advance within the frame
  } divStrobeT;

  // Status from the datapath back to the control.
  typedef struct packed {
    logic lastCycle;  // main remainder has reached zero
    logic swallowOn;  // swallow remainder is nonzero
  } divStatusT;

endpackage

// File: rtl/swallowDivPath.sv
module swallowDivPath
  import swallowDivider_pkg::*;
#(
  parameter int A_W     = 7,
  parameter int N_W     = 11,
  parameter int MIN_DIV = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobeT      strobes,
  input  logic [A_W-1:0] swallowCfg,
  input  logic [N_W-1:0] mainCfg,
  output divStatusT      status
);
  localparam logic [N_W-1:0] MIN_N = N_W'(MIN_DIV);

  logic [N_W-1:0] mainRem;
  logic [A_W-1:0] swRem;
  logic [N_W-1:0] mainLoad;

  always_comb begin
    mainLoad = ((mainCfg < MIN_N) ? MIN_N : mainCfg) - N_W'(1);
    status.lastCycle = (mainRem == '0);
    status.swallowOn = (swRem != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainRem <= '0;
      swRem   <= '0;
    end else if (strobes.clear) begin
      mainRem <= '0;
      swRem   <= '0;
    end else if (strobes.load) begin
      mainRem <= mainLoad;
      swRem   <= swallowCfg;
    end else if (strobes.step) begin
      mainRem <= mainRem - N_W'(1);
      if (swRem != '0) swRem <= swRem - A_W'(1);
    end
  end

  // R1: within a frame the main remainder counts down by one per cycle
  assert_main_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step && !strobes.clear && !strobes.load |=> mainRem == $past(mainRem) - N_W'(1));

  // R4: a reload never starts a frame shorter than the minimum
  assert_main_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && !strobes.clear |=> mainRem >= MIN_N - N_W'(1));

  // R2: between reloads the swallow remainder never grows
  assert_swallow_monotone_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load && !strobes.clear |=> swRem <= $past(swRem));
endmodule

// File: rtl/swallowDivCtl.sv
module swallowDivCtl
  import swallowDivider_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  divStatusT status,
  output divStrobeT strobes,
  output logic      modCtl,
  output logic      fpPulse
);
  logic active;
  logic frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= enable;
  end

  always_comb begin
    frameEnd      = active && status.lastCycle;
    strobes.clear = !enable;
    strobes.load  = enable && (!active || frameEnd);
    strobes.step  = enable && active && !frameEnd;
    modCtl        = active && status.swallowOn;
    fpPulse       = frameEnd;
  end

  // R1: the comparison pulse is never wider than one cycle
  assert_fp_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    fpPulse |=> !fpPulse);

  // R2: the modulus select only rises at the start of a frame
  assert_mod_rise_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> ($past(fpPulse) || !$past(active)));

  // R7: one edge after enable is seen low, both outputs are quiet
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !modCtl && !fpPulse);
endmodule

// File: rtl/swallowRefDiv.sv
module swallowRefDiv #(
  parameter int R_W     = 14,
  parameter int MIN_DIV = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [R_W-1:0] refCfg,
  output logic           frPulse
);
  localparam logic [R_W-1:0] MIN_R = R_W'(MIN_DIV);

  logic           active;
  logic [R_W-1:0] refRem;
  logic [R_W-1:0] refLoad;

  always_comb begin
    refLoad = ((refCfg < MIN_R) ? MIN_R : refCfg) - R_W'(1);
    frPulse = active && (refRem == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      refRem <= '0;
    end else begin
      active <= enable;
      if (!enable)                   refRem <= '0;
      else if (!active || frPulse)   refRem <= refLoad;
      else                           refRem <= refRem - R_W'(1);
    end
  end

  // R5: the reference pulse is never wider than one cycle
  assert_fr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    frPulse |=> !frPulse);

  // R7: one edge after enable is seen low, the reference pulse is quiet
  assert_fr_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !frPulse);
endmodule

// File: rtl/swallowDivider.sv
module swallowDivider
  import swallowDivider_pkg::*;
#(
  parameter int A_W     = 7,
  parameter int N_W     = 11,
  parameter int R_W     = 14,
  parameter int MIN_DIV = 5
) (
  input  logic           pscClk,
  input  logic           refClk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [A_W-1:0] swallowCfg,
  input  logic [N_W-1:0] mainCfg,
  input  logic [R_W-1:0] refCfg,
  output logic           modCtl,
  output logic           fpPulse,
  output logic           frPulse
);
  divStrobeT strobes;
  divStatusT status;

  swallowDivCtl ctl_i (
    .clk(pscClk), .rstN(rstN), .enable(enable), .status(status),
    .strobes(strobes), .modCtl(modCtl), .fpPulse(fpPulse)
  );

  swallowDivPath #(.A_W(A_W), .N_W(N_W), .MIN_DIV(MIN_DIV)) path_i (
    .clk(pscClk), .rstN(rstN), .strobes(strobes),
    .swallowCfg(swallowCfg), .mainCfg(mainCfg), .status(status)
  );

  swallowRefDiv #(.R_W(R_W), .MIN_DIV(MIN_DIV)) ref_i (
    .clk(refClk), .rstN(rstN), .enable(enable),
    .refCfg(refCfg), .frPulse(frPulse)
  );
endmodule

// File: tb/swallowDivider_tb_top.sv
module swallowDivider_tb_top;
  logic        pscClk = 1'b0;
  logic        refClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  swallowCfg = '0;
  logic [10:0] mainCfg = 11'd5;
  logic [13:0] refCfg = 14'd5;
  logic        modCtl, fpPulse, frPulse;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2 pscClk = ~pscClk;   // 250 MHz
  always #3 refClk = ~refClk;

  swallowDivider dut_i (
    .pscClk(pscClk), .refClk(refClk), .rstN(rstN), .enable(enable),
    .swallowCfg(swallowCfg), .mainCfg(mainCfg), .refCfg(refCfg),
    .modCtl(modCtl), .fpPulse(fpPulse), .frPulse(frPulse)
  );

  localparam int NV = 6;
  localparam int VA [NV] = '{7,   0, 127,  3,  4,   1};
  localparam int VN [NV] = '{291, 5, 2047, 2,  10,  6};
  localparam int VR [NV] = '{384, 5, 16383, 3, 7, 100};
  localparam int EN [NV] = '{291, 5, 2047, 5,  10,  6};
  localparam int ER [NV] = '{384, 5, 16383, 5, 7, 100};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitFp(input int limit);
    int n = 0;
    while (n < limit) begin
      @(negedge pscClk);
      n++;
      if (fpPulse) break;
    end
    if (n >= limit) check(0, "R1 fp timeout", n, limit);
  endtask

  // Counts prescaler cycles from the one after a comparison pulse up to the next one.
  task automatic measureFrame(input bit swap, input int nA, input int nN,
                              output int len, output int highs);
    len = 0; highs = 0;
    while (len < 5000) begin
      @(negedge pscClk);
      len++;
      if (modCtl) highs++;
      if (swap && len == 1) begin
        swallowCfg = 7'(nA);
        mainCfg    = 11'(nN);
      end
      if (fpPulse) break;
    end
  endtask

  task automatic measureRef(output int len);
    int n = 0;
    while (n < 40000) begin
      @(negedge refClk);
      n++;
      if (frPulse) break;
    end
    len = 0;
    while (len < 40000) begin
      @(negedge refClk);
      len++;
      if (frPulse) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge pscClk);
    if (!done) begin
      check(0, "R1 watchdog", 190000, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int len, highs, vco;
    // R8: outputs low while reset is held
    repeat (3) @(negedge pscClk);
    check(!modCtl && !fpPulse && !frPulse, "R8 reset outputs",
          {modCtl, fpPulse, frPulse}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge pscClk);
    check(!modCtl && !fpPulse && !frPulse, "R7 idle before enable",
          {modCtl, fpPulse, frPulse}, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge pscClk);
      enable = 1'b0;
      swallowCfg = 7'(VA[v]);
      mainCfg    = 11'(VN[v]);
      refCfg     = 14'(VR[v]);
      repeat (4) @(negedge pscClk);
      enable = 1'b1;
      waitFp(5000);
      measureFrame(0, 0, 0, len, highs);
      check(len == EN[v], "R1 R4 frame length", len, EN[v]);
      check(highs == VA[v], "R2 swallow cycles", highs, VA[v]);
      for (int p = 64; p <= 128; p += 64) begin
        vco = highs * (p + 1) + (len - highs) * p;
        check(vco == p * VN[v] + VA[v] || VN[v] < 5, "R3 total ratio", vco, p * VN[v] + VA[v]);
        check(vco == p * EN[v] + VA[v], "R3 R4 clamped ratio", vco, p * EN[v] + VA[v]);
      end
      measureRef(len);
      check(len == ER[v], "R5 reference spacing", len, ER[v]);
    end

    // R7: idle outputs after enable drops
    @(negedge pscClk);
    enable = 1'b0;
    repeat (2) @(negedge pscClk);
    for (int k = 0; k < 8; k++) begin
      @(negedge pscClk);
      check(!modCtl && !fpPulse && !frPulse, "R7 idle outputs",
            {modCtl, fpPulse, frPulse}, 0);
    end

    // R7: first comparison pulse N cycles after enable rises
    swallowCfg = 7'd3;
    mainCfg    = 11'd20;
    refCfg     = 14'd9;
    @(negedge pscClk);
    enable = 1'b1;
    len = 0;
    while (len < 100) begin
      @(negedge pscClk);
      len++;
      if (fpPulse) break;
    end
    check(len == 20, "R7 first frame after enable", len, 20);

    // R6: mid-frame change is held until the next boundary
    measureFrame(1, 6, 12, len, highs);
    check(len == 20, "R6 old length kept", len, 20);
    check(highs == 3, "R6 old swallow kept", highs, 3);
    measureFrame(0, 0, 0, len, highs);
    check(len == 12, "R6 new length taken", len, 12);
    check(highs == 6, "R6 new swallow taken", highs, 6);

    // R2: swallow count of zero keeps modulus select low
    swallowCfg = 7'd0;
    waitFp(100);
    measureFrame(0, 0, 0, len, highs);
    check(highs == 0, "R2 zero swallow", highs, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule